// File: doc/BRIEF.md
# 16-bit Event Timestamp Timer

This block is a 16-bit up counter that advances by one on each cycle in which a tick enable is high. It timestamps external events by copying the counter into a capture register. An event is either an edge on a capture pin or a toggle of a comparator output bit. A source-select input chooses between the two. For the pin, an edge-select input chooses the rising or the falling edge. Both inputs are resynchronized to the clock before edge detection. Capture does not depend on the tick, so events are still timestamped while the counter is stopped.

The counter wraps from 65535 to 0 and raises an overflow flag when it does. When clear-on-match is enabled, a tick that finds the counter equal to compare value A returns the counter to 0. This gives a fixed period of compare A + 1 ticks. Software uses a small register port to load the counter and compare A, to read back the captured timestamp and to clear flags. Each capture raises a capture flag. A capture that arrives while that flag is still set overwrites the timestamp and sets an overrun bit.

Top module: `capture_timer16`

## Requirements
- R1: After reset, the counter, compare A, the capture register, the control bit and all three flags read 0.
- R2: On a cycle with tick_i high, the counter increments by one. With tick_i low it holds its value. A register write to the counter takes precedence over the tick.
- R3: A tick at count 65535 that is not a compare-A match wraps the counter to 0 and sets the overflow flag, which stays set until cleared.
- R4: With control bit 0 set, a tick while the counter equals compare A loads 0 instead of incrementing and does not set the overflow flag.
- R5: With src_sel_i = 0, an edge on cap_pin_i triggers a capture: rising if edge_sel_i = 0, falling if edge_sel_i = 1. The opposite edge has no effect.
- R6: With src_sel_i = 1, every toggle of cmp_bit_i (either direction) triggers a capture, and cap_pin_i is ignored. With src_sel_i = 0, cmp_bit_i is ignored.
- R7: An input change is seen by the clock edge after it is driven. It becomes an event two edges later and is registered on the third edge. The timestamp is the counter value in the cycle between the second and third edges.
- R8: Each capture sets the capture flag. A capture while that flag is already set overwrites the timestamp and also sets the overrun bit.
- R9: Captures occur and store the held count while tick_i stays low.
- R10: The register map is as follows. Address 0 is the counter (read/write). Address 1 is compare A (read/write). Address 2 is the capture value (read-only). Address 3 is status, where writing 1 clears a bit: bit 0 overflow, bit 1 capture, bit 2 overrun. Address 4 is control, with bit 0 enabling clear-on-match. reg_rdata_o is combinational from reg_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter advance enable |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| cmp_bit_i | input | 1 | Asynchronous comparator output |
| edge_sel_i | input | 1 | 0 rising, 1 falling (pin source) |
| src_sel_i | input | 1 | 0 pin, 1 comparator |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| cap_flag_o | output | 1 | Capture flag |
| ovf_flag_o | output | 1 | Overflow flag |

## Verification
A counter write or tick appears one edge later. A capture input change appears in the flag and timestamp three edges after it is driven, with the stored value taken from the cycle before the third edge. The bench drives on falling edges and reads just after a falling edge. It waits four cycles before reading capture results and checks the flag both before and after the third edge. In the timing case with the tick running, the expected timestamp is the loaded value plus one. That is exactly the count one tick before the capture edge.

// File: rtl/ct_pkg.sv
package ct_pkg;
  typedef enum logic [2:0] {
    SEL_CNT  = 3'd0,
    SEL_CMPA = 3'd1,
    SEL_CAPT = 3'd2,
    SEL_STAT = 3'd3,
    SEL_CTRL = 3'd4
  } reg_sel_e;

  localparam int ST_OVF = 0;
  localparam int ST_CAP = 1;
  localparam int ST_OVR = 2;
  localparam int CTRL_CTC = 0;
endpackage

// File: rtl/ct_event_det.sv
module ct_event_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_pin_i,
  input  logic cmp_bit_i,
  input  logic edge_sel_i,
  input  logic src_sel_i,
  output logic event_o
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] raw;
  logic [NSRC-1:0] cur;
  logic [NSRC-1:0] prv;

  assign raw = {cmp_bit_i, cap_pin_i};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], raw[s]};
        prev_q  <= chain_q[STAGES-1];
      end
    end
    assign cur[s] = chain_q[STAGES-1];
    assign prv[s] = prev_q;
  end

  logic pin_rise, pin_fall, cmp_chg;
  assign pin_rise = cur[0] & ~prv[0];
  assign pin_fall = ~cur[0] & prv[0];
  assign cmp_chg  = cur[1] ^ prv[1];

  always_comb begin
    if (src_sel_i) event_o = cmp_chg;
    else           event_o = edge_sel_i ? pin_fall : pin_rise;
  end

  assert_cmp_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_sel_i && !pin_rise && !pin_fall) |-> !event_o);
endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] cmpa_i,
  input  logic         ctc_en_i,
  input  logic         ovf_clr_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_flag_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;
  logic         ovf_q;
  logic         hit, wrap;

  assign hit  = ctc_en_i && (cnt_q == cmpa_i);
  assign wrap = tick_i && !load_i && !hit && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (wrap)      ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign cnt_o      = cnt_q;
  assign ovf_flag_o = ovf_q;

  assert_tick_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> (cnt_o == $past(cnt_o)));
  assert_wrap_ovf_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !ctc_en_i && cnt_o == CNT_MAX) |=> (ovf_flag_o && cnt_o == '0));
  assert_ctc_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && ctc_en_i && cnt_o == cmpa_i) |=> (cnt_o == '0));
endmodule

// File: rtl/ct_capture.sv
module ct_capture #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         event_i,
  input  logic [W-1:0] cnt_i,
  input  logic         cap_clr_i,
  input  logic         ovr_clr_i,
  output logic [W-1:0] capt_o,
  output logic         cap_flag_o,
  output logic         overrun_o
);
  logic [W-1:0] capt_q;
  logic         flag_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      capt_q <= '0;
    else if (event_i) capt_q <= cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (event_i)        flag_q <= 1'b1;
      else if (cap_clr_i) flag_q <= 1'b0;
      if (event_i && flag_q) ovr_q <= 1'b1;
      else if (ovr_clr_i)    ovr_q <= 1'b0;
    end
  end

  assign capt_o     = capt_q;
  assign cap_flag_o = flag_q;
  assign overrun_o  = ovr_q;

  assert_capture_value_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> (capt_o == $past(cnt_i)));
  assert_flag_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> cap_flag_o);
  assert_overrun_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && cap_flag_o) |=> overrun_o);
endmodule

// File: rtl/ct_regs.sv
module ct_regs
  import ct_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   addr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] capt_i,
  input  logic         ovf_i,
  input  logic         cap_i,
  input  logic         ovr_i,
  output logic [W-1:0] cmpa_o,
  output logic         ctc_en_o,
  output logic         cnt_load_o,
  output logic         ovf_clr_o,
  output logic         cap_clr_o,
  output logic         ovr_clr_o,
  output logic [W-1:0] rdata_o
);
  reg_sel_e     sel;
  logic [W-1:0] cmpa_q;
  logic         ctc_q;
  logic         stat_wr;

  assign sel     = reg_sel_e'(addr_i);
  assign stat_wr = wr_i && (sel == SEL_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmpa_q <= '0;
      ctc_q  <= 1'b0;
    end else if (wr_i) begin
      if (sel == SEL_CMPA) cmpa_q <= wdata_i;
      if (sel == SEL_CTRL) ctc_q  <= wdata_i[CTRL_CTC];
    end
  end

  assign cmpa_o     = cmpa_q;
  assign ctc_en_o   = ctc_q;
  assign cnt_load_o = wr_i && (sel == SEL_CNT);
  assign ovf_clr_o  = stat_wr && wdata_i[ST_OVF];
  assign cap_clr_o  = stat_wr && wdata_i[ST_CAP];
  assign ovr_clr_o  = stat_wr && wdata_i[ST_OVR];

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_CNT:  rdata_o = cnt_i;
      SEL_CMPA: rdata_o = cmpa_q;
      SEL_CAPT: rdata_o = capt_i;
      SEL_STAT: begin
        rdata_o[ST_OVF] = ovf_i;
        rdata_o[ST_CAP] = cap_i;
        rdata_o[ST_OVR] = ovr_i;
      end
      SEL_CTRL: rdata_o[CTRL_CTC] = ctc_q;
      default:  rdata_o = '0;
    endcase
  end

  assert_capt_readonly_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel == SEL_CAPT && !cap_i) |=> (capt_i == $past(capt_i) || cap_i));
endmodule

// File: rtl/capture_timer16.sv
module capture_timer16 #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cap_pin_i,
  input  logic             cmp_bit_i,
  input  logic             edge_sel_i,
  input  logic             src_sel_i,
  input  logic [2:0]       reg_addr_i,
  input  logic             reg_wr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  output logic             cap_flag_o,
  output logic             ovf_flag_o
);
  logic             evt;
  logic [CNT_W-1:0] cnt, capt, cmpa;
  logic             ctc_en, cnt_load, ovf_clr, cap_clr, ovr_clr;
  logic             ovf, cap, ovr;

  ct_event_det #(.STAGES(SYNC_STAGES)) u_evt (
    .clk_i, .rst_ni, .cap_pin_i, .cmp_bit_i, .edge_sel_i, .src_sel_i,
    .event_o(evt)
  );

  ct_counter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .load_i(cnt_load), .load_val_i(reg_wdata_i), .cmpa_i(cmpa),
    .ctc_en_i(ctc_en), .ovf_clr_i(ovf_clr),
    .cnt_o(cnt), .ovf_flag_o(ovf)
  );

  ct_capture #(.W(CNT_W)) u_cap (
    .clk_i, .rst_ni, .event_i(evt), .cnt_i(cnt),
    .cap_clr_i(cap_clr), .ovr_clr_i(ovr_clr),
    .capt_o(capt), .cap_flag_o(cap), .overrun_o(ovr)
  );

  ct_regs #(.W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .addr_i(reg_addr_i), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
    .cnt_i(cnt), .capt_i(capt), .ovf_i(ovf), .cap_i(cap), .ovr_i(ovr),
    .cmpa_o(cmpa), .ctc_en_o(ctc_en), .cnt_load_o(cnt_load),
    .ovf_clr_o(ovf_clr), .cap_clr_o(cap_clr), .ovr_clr_o(ovr_clr),
    .rdata_o(reg_rdata_o)
  );

  assign cap_flag_o = cap;
  assign ovf_flag_o = ovf;
endmodule

// File: tb/capture_timer16_tb.sv
module capture_timer16_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {src, edge, pin0, pin1, cmp0, cmp1, expect, load[15:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h1234},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2222},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'hBEEF},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h3333},
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0055},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'hA5A5},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h4444},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h5555}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, pin = 1'b0, cmp = 1'b0, esel = 1'b0, ssel = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        cap_flag, ovf_flag;
  int          n_chk = 0, n_bad = 0;
  logic [15:0] rv, pre;

  always #(CLK_PERIOD/2) clk = ~clk;

  capture_timer16 u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cap_pin_i(pin), .cmp_bit_i(cmp),
    .edge_sel_i(esel), .src_sel_i(ssel), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cap_flag_o(cap_flag), .ovf_flag_o(ovf_flag)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd_reg(a[2:0], rv);
      chk("R1 reset reg", rv, 16'h0000);
    end
    chk("R1 flags", {14'b0, cap_flag, ovf_flag}, 16'h0000);

    // R2 increment and hold
    @(negedge clk);
    wr_reg(3'd0, 16'd10);
    tick = 1'b1;
    repeat (5) @(negedge clk);
    tick = 1'b0;
    rd_reg(3'd0, rv); chk("R2 tick count", rv, 16'd15);
    repeat (3) @(negedge clk);
    rd_reg(3'd0, rv); chk("R2 hold", rv, 16'd15);
    addr = 3'd0; wdata = 16'd100; wr = 1'b1; tick = 1'b1;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0;
    rd_reg(3'd0, rv); chk("R2 write beats tick", rv, 16'd100);

    // R3 wrap and overflow flag
    wr_reg(3'd0, 16'hFFFE);
    tick = 1'b1;
    @(negedge clk);
    chk("R3 no ovf before wrap", {15'b0, ovf_flag}, 16'h0000);
    @(negedge clk);
    tick = 1'b0;
    rd_reg(3'd0, rv); chk("R3 wrap value", rv, 16'h0000);
    chk("R3 ovf flag", {15'b0, ovf_flag}, 16'h0001);
    rd_reg(3'd3, rv); chk("R10 status ovf bit0", rv, 16'h0001);
    wr_reg(3'd3, 16'h0001);
    chk("R10 ovf cleared", {15'b0, ovf_flag}, 16'h0000);

    // R4 clear on compare A
    wr_reg(3'd1, 16'd5);
    wr_reg(3'd4, 16'h0001);
    rd_reg(3'd4, rv); chk("R10 ctrl readback", rv, 16'h0001);
    wr_reg(3'd0, 16'd3);
    tick = 1'b1;
    repeat (3) @(negedge clk);
    rd_reg(3'd0, rv); chk("R4 match clears", rv, 16'd0);
    chk("R4 no ovf", {15'b0, ovf_flag}, 16'h0000);
    @(negedge clk);
    tick = 1'b0;
    rd_reg(3'd0, rv); chk("R4 restart", rv, 16'd1);
    wr_reg(3'd4, 16'h0000);

    // R5 R6 R9 vector table, tick held low
    for (int i = 0; i < NVEC; i++) begin
      ssel = VEC[i][22]; esel = VEC[i][21];
      pin = VEC[i][20]; cmp = VEC[i][18];
      repeat (5) @(negedge clk);
      wr_reg(3'd0, VEC[i][15:0]);
      wr_reg(3'd3, 16'h0007);
      rd_reg(3'd2, pre);
      pin = VEC[i][19]; cmp = VEC[i][17];
      repeat (4) @(negedge clk);
      rd_reg(3'd2, rv);
      if (VEC[i][16]) begin
        chk("R5 R6 R9 captured value", rv, VEC[i][15:0]);
        chk("R8 capture flag", {15'b0, cap_flag}, 16'h0001);
      end else begin
        chk("R5 R6 ignored value", rv, pre);
        chk("R5 R6 ignored flag", {15'b0, cap_flag}, 16'h0000);
      end
    end

    // R7 timing with tick running
    ssel = 1'b0; esel = 1'b0; pin = 1'b0; cmp = 1'b0;
    repeat (5) @(negedge clk);
    wr_reg(3'd3, 16'h0007);
    addr = 3'd0; wdata = 16'h0100; wr = 1'b1; tick = 1'b1; pin = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    @(negedge clk);
    chk("R7 flag not yet", {15'b0, cap_flag}, 16'h0000);
    @(negedge clk);
    tick = 1'b0;
    chk("R7 flag on third edge", {15'b0, cap_flag}, 16'h0001);
    rd_reg(3'd2, rv); chk("R7 timestamp", rv, 16'h0101);
    rd_reg(3'd3, rv); chk("R8 no overrun yet", rv & 16'h0004, 16'h0000);

    // R8 overrun
    pin = 1'b0;
    repeat (4) @(negedge clk);
    wr_reg(3'd0, 16'h7777);
    pin = 1'b1;
    repeat (4) @(negedge clk);
    rd_reg(3'd2, rv); chk("R8 overwritten", rv, 16'h7777);
    rd_reg(3'd3, rv); chk("R8 overrun set", rv & 16'h0006, 16'h0006);
    wr_reg(3'd2, 16'h1111);
    rd_reg(3'd2, rv); chk("R10 capture read-only", rv, 16'h7777);
    wr_reg(3'd3, 16'h0007);
    rd_reg(3'd3, rv); chk("R10 status cleared", rv, 16'h0000);

    finish_run();
  end
endmodule